// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch

This block produces the address that a multicycle controller uses to read its microcode store. A small micro-PC register holds the current micro-address. Each microinstruction supplies a 2-bit sequencing code, and that code picks the next micro-address. There are three choices: go back to address 0, which is where the fetch routine starts; jump to a routine chosen by the instruction's opcode; or step to the following address. The opcode lookup uses a fixed table inside the block. The microcode store and the datapath it drives sit outside the block.

A memory wait input freezes the micro-PC. While it is high, the controller stays in its current micro-state for as long as a slow memory needs. Wait states therefore need no extra microcode lines.

Top module: `useq_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, `uaddr` is 0 after that edge. Reset is synchronous and active high.
- R2: Sequencing code 2'b00 (fetch), with `mem_wait` low, makes `uaddr` 0 after the next edge.
- R3: Sequencing code 2'b01 (dispatch), with `mem_wait` low, loads the table target for `opcode`. The table is: opcode 6'b000000 gives 4, 6'b000100 gives 3, 6'b001101 gives 6, 6'b100011 gives 8, and 6'b101011 gives 11.
- R4: A dispatch with any opcode that is not in the R3 table loads address 0.
- R5: Sequencing code 2'b10 (step), with `mem_wait` low, loads `uaddr`+1 modulo 16, so address 15 steps to 0.
- R6: Sequencing code 2'b11 is reserved. With `mem_wait` low it loads address 0.
- R7: While `mem_wait` is high and `rst` is low, `uaddr` keeps its value at the edge, whatever the sequencing code and opcode are.
- R8: Reset wins over `mem_wait`. When both are high, `uaddr` becomes 0.
- R9: The standard microprogram drives the sequencing code from the current address: step at 0, 4, 6, 8, 9 and 11; dispatch at 1; fetch at 3, 5, 7, 10 and 12. Starting at 0, this visits the following addresses:
  - opcode 000000: 1, 4, 5, 0
  - opcode 000100: 1, 3, 0
  - opcode 001101: 1, 6, 7, 0
  - opcode 100011: 1, 8, 9, 10, 0
  - opcode 101011: 1, 11, 12, 0

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_ctl | input | 2 | Sequencing code from the current microinstruction |
| opcode | input | 6 | Opcode field of the instruction being executed |
| mem_wait | input | 1 | Memory busy; freezes the micro-PC |
| uaddr | output | 4 | Current micro-address |

## Verification
The wait freeze can fall in the same cycle as a dispatch, a step or a fetch. The bench raises `mem_wait` together with each sequencing code, and with a valid opcode present. It checks that the address has not moved, then lowers `mem_wait` and checks that the pending action takes effect on the next edge. The bench also asserts reset and wait together and expects address 0. During a full microprogram walk for a load, it inserts a two-cycle freeze in the middle and checks that the visited path only lengthens in place.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UADDR_W = 4;
    localparam int OPC_W   = 6;

    typedef enum logic [1:0] {
        AC_FETCH    = 2'b00,
        AC_DISPATCH = 2'b01,
        AC_STEP     = 2'b10,
        AC_RSVD     = 2'b11
    } addr_ctl_e;

    localparam logic [OPC_W-1:0] OP_REG_ALU = 6'b000000;
    localparam logic [OPC_W-1:0] OP_BR_EQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OP_OR_IMM  = 6'b001101;
    localparam logic [OPC_W-1:0] OP_LOAD    = 6'b100011;
    localparam logic [OPC_W-1:0] OP_STORE   = 6'b101011;

    localparam logic [3:0] TGT_REG_ALU = 4'd4;
    localparam logic [3:0] TGT_BR_EQ   = 4'd3;
    localparam logic [3:0] TGT_OR_IMM  = 4'd6;
    localparam logic [3:0] TGT_LOAD    = 4'd8;
    localparam logic [3:0] TGT_STORE   = 4'd11;
    localparam logic [3:0] TGT_NONE    = 4'd0;

    typedef struct packed {
        logic [UADDR_W-1:0] zero;
        logic [UADDR_W-1:0] disp;
        logic [UADDR_W-1:0] incr;
    } next_cand_t;

    function automatic logic [3:0] dispatch_target(input logic [OPC_W-1:0] op);
        logic [3:0] t;
        case (op)
            OP_REG_ALU: t = TGT_REG_ALU;
            OP_BR_EQ:   t = TGT_BR_EQ;
            OP_OR_IMM:  t = TGT_OR_IMM;
            OP_LOAD:    t = TGT_LOAD;
            OP_STORE:   t = TGT_STORE;
            default:    t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/useq_dispatch_rom.sv
module useq_dispatch_rom #(
    parameter int AW = useq_pkg::UADDR_W,
    parameter int OW = useq_pkg::OPC_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] target
);
    import useq_pkg::*;

    localparam int TW = 4;

    logic [TW-1:0] raw;

    always_comb begin
        raw = dispatch_target(opcode[OPC_W-1:0]);
    end

    generate
        if (AW > TW) begin : g_wide
            assign target = {{(AW-TW){1'b0}}, raw};
        end else begin : g_narrow
            assign target = raw[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel #(
    parameter int AW = useq_pkg::UADDR_W
) (
    input  logic [1:0]    addr_ctl,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] disp_tgt,
    output logic [AW-1:0] nxt
);
    import useq_pkg::*;

    next_cand_t cand;
    addr_ctl_e  ctl;

    always_comb begin
        cand.zero = '0;
        cand.disp = disp_tgt;
        cand.incr = cur + AW'(1);
        ctl       = addr_ctl_e'(addr_ctl);
        case (ctl)
            AC_DISPATCH: nxt = cand.disp;
            AC_STEP:     nxt = cand.incr;
            AC_FETCH:    nxt = cand.zero;
            default:     nxt = cand.zero;
        endcase
    end

endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg #(
    parameter int AW = useq_pkg::UADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [AW-1:0] nxt,
    output logic [AW-1:0] upc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upc <= '0;
        end else if (!hold) begin
            upc <= nxt;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (upc == '0));

    assert_reset_beats_wait_R8: assert property (@(posedge clk)
        (rst && hold) |=> (upc == '0));

    assert_wait_freezes_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(upc));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
    parameter int AW = useq_pkg::UADDR_W,
    parameter int OW = useq_pkg::OPC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    addr_ctl,
    input  logic [OW-1:0] opcode,
    input  logic          mem_wait,
    output logic [AW-1:0] uaddr
);
    import useq_pkg::*;

    logic [AW-1:0] disp_tgt;
    logic [AW-1:0] nxt;

    useq_dispatch_rom #(.AW(AW), .OW(OW)) u_rom (
        .opcode (opcode),
        .target (disp_tgt)
    );

    useq_next_sel #(.AW(AW)) u_sel (
        .addr_ctl (addr_ctl),
        .cur      (uaddr),
        .disp_tgt (disp_tgt),
        .nxt      (nxt)
    );

    useq_upc_reg #(.AW(AW)) u_upc (
        .clk  (clk),
        .rst  (rst),
        .hold (mem_wait),
        .nxt  (nxt),
        .upc  (uaddr)
    );

    assert_fetch_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_wait && addr_ctl == 2'b00) |=> (uaddr == '0));

    assert_dispatch_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_wait && addr_ctl == 2'b01 && opcode == OW'(6'b100011)) |=> (uaddr == AW'(8)));

    assert_dispatch_unknown_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_wait && addr_ctl == 2'b01 && opcode == OW'(6'b111111)) |=> (uaddr == '0));

    assert_step_incr_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_wait && addr_ctl == 2'b10) |=> (uaddr == AW'($past(uaddr) + AW'(1))));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_wait && addr_ctl == 2'b11) |=> (uaddr == '0));

endmodule

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr_ctl = 2'b00;
    logic [5:0] opcode = 6'b0;
    logic       mem_wait = 1'b0;
    logic [3:0] uaddr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    useq_sequencer i_useq_sequencer (
        .clk      (clk),
        .rst      (rst),
        .addr_ctl (addr_ctl),
        .opcode   (opcode),
        .mem_wait (mem_wait),
        .uaddr    (uaddr)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: uaddr=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic [1:0] c, input logic [5:0] op, input logic w);
        @(negedge clk);
        rst = r; addr_ctl = c; opcode = op; mem_wait = w;
        @(posedge clk);
        #1;
    endtask

    task automatic go_to(input logic [3:0] a);
        cyc(1'b1, 2'b00, 6'd0, 1'b0);
        for (int i = 0; i < int'(a); i++) cyc(1'b0, 2'b10, 6'd0, 1'b0);
    endtask

    task automatic t_reset();
        cyc(1'b1, 2'b10, 6'd0, 1'b0);
        check("R1 reset", uaddr, 4'd0);
        cyc(1'b1, 2'b10, 6'd0, 1'b0);
        check("R1 reset held", uaddr, 4'd0);
    endtask

    task automatic t_step();
        go_to(4'd0);
        for (int i = 1; i <= 15; i++) begin
            cyc(1'b0, 2'b10, 6'd0, 1'b0);
            check("R5 step", uaddr, 4'(i));
        end
        cyc(1'b0, 2'b10, 6'd0, 1'b0);
        check("R5 wrap 15->0", uaddr, 4'd0);
    endtask

    task automatic t_fetch();
        go_to(4'd5);
        cyc(1'b0, 2'b00, 6'b100011, 1'b0);
        check("R2 fetch", uaddr, 4'd0);
        go_to(4'd13);
        cyc(1'b0, 2'b00, 6'd0, 1'b0);
        check("R2 fetch from 13", uaddr, 4'd0);
    endtask

    task automatic t_dispatch();
        logic [5:0] ops [5] = '{6'b000000, 6'b000100, 6'b001101, 6'b100011, 6'b101011};
        logic [3:0] tgt [5] = '{4'd4, 4'd3, 4'd6, 4'd8, 4'd11};
        for (int i = 0; i < 5; i++) begin
            go_to(4'd1);
            cyc(1'b0, 2'b01, ops[i], 1'b0);
            check("R3 dispatch", uaddr, tgt[i]);
        end
    endtask

    task automatic t_unknown();
        logic [5:0] ops [3] = '{6'b111111, 6'b000010, 6'b100010};
        for (int i = 0; i < 3; i++) begin
            go_to(4'd1);
            cyc(1'b0, 2'b01, ops[i], 1'b0);
            check("R4 unknown opcode", uaddr, 4'd0);
        end
    endtask

    task automatic t_reserved();
        go_to(4'd3);
        cyc(1'b0, 2'b11, 6'b100011, 1'b0);
        check("R6 reserved code", uaddr, 4'd0);
    endtask

    task automatic t_wait();
        go_to(4'd4);
        for (int c = 0; c < 4; c++) begin
            cyc(1'b0, 2'(c), 6'b101011, 1'b1);
            check("R7 wait holds", uaddr, 4'd4);
        end
        go_to(4'd1);
        cyc(1'b0, 2'b01, 6'b101011, 1'b1);
        check("R7 wait with dispatch", uaddr, 4'd1);
        cyc(1'b0, 2'b01, 6'b101011, 1'b0);
        check("R3 dispatch after wait", uaddr, 4'd11);
    endtask

    task automatic t_reset_wait();
        go_to(4'd7);
        cyc(1'b1, 2'b10, 6'd0, 1'b1);
        check("R8 reset over wait", uaddr, 4'd0);
    endtask

    function automatic logic [1:0] prog_code(input logic [3:0] a);
        case (a)
            4'd0, 4'd4, 4'd6, 4'd8, 4'd9, 4'd11: return 2'b10;
            4'd1:                               return 2'b01;
            default:                            return 2'b00;
        endcase
    endfunction

    task automatic walk(input logic [5:0] op, input logic [19:0] path, input int len, input int freeze_at);
        go_to(4'd0);
        for (int i = 0; i < len; i++) begin
            if (i == freeze_at) begin
                logic [3:0] here;
                here = uaddr;
                cyc(1'b0, prog_code(uaddr), op, 1'b1);
                check("R7 freeze mid-walk", uaddr, here);
                cyc(1'b0, prog_code(uaddr), op, 1'b1);
                check("R7 freeze mid-walk", uaddr, here);
            end
            cyc(1'b0, prog_code(uaddr), op, 1'b0);
            check("R9 microprogram walk", uaddr, path[4*i +: 4]);
        end
    endtask

    initial begin
        t_reset();
        t_step();
        t_fetch();
        t_dispatch();
        t_unknown();
        t_reserved();
        t_wait();
        t_reset_wait();
        walk(6'b000000, {4'd0, 4'd0, 4'd5, 4'd4, 4'd1}, 4, -1);
        walk(6'b000100, {4'd0, 4'd0, 4'd0, 4'd3, 4'd1}, 3, -1);
        walk(6'b001101, {4'd0, 4'd0, 4'd7, 4'd6, 4'd1}, 4, -1);
        walk(6'b100011, {4'd0, 4'd10, 4'd9, 4'd8, 4'd1}, 5, -1);
        walk(6'b100011, {4'd0, 4'd10, 4'd9, 4'd8, 4'd1}, 5, 2);
        walk(6'b101011, {4'd0, 4'd0, 4'd12, 4'd11, 4'd1}, 4, -1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule